// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

This block turns two asynchronous interrupt pins into request flags for an interrupt controller. Each pin first crosses into the clock domain through a short synchroniser. It is then captured once per machine cycle, on a one-clock sample strobe that a cycle timer supplies. A per-channel sense bit chooses level or edge operation. In edge operation, a two-bit polarity field chooses falling edges, rising edges or both.

Every request flag goes straight to the interrupt controller. The flag drops when the core acknowledges the matching vector. Software can also force any flag high or low through a per-bit write port. When several sources hit the same flag in one clock, a fixed precedence decides: the acknowledge wins first, the hardware update comes second, and the software write comes last.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset every flag is 0, and the stored previous sample of each pin is 1. A pin held high from reset therefore never produces an edge.
- R2: With the sense bit at 0 (level), each sample strobe loads the flag with the inverse of the sampled pin. A low pin gives a flag of 1 and a high pin gives a flag of 0.
- R3: A pin value reaches the sampling stage two clocks after it is registered by the synchroniser. A flag changes only on a clock where the strobe, the acknowledge or a software write is active.
- R4: With the sense bit at 1 and the polarity field at 00, the flag is set when the new sample is 0 and the previous sample was 1.
- R5: With the polarity field at 01, the flag is set when the new sample is 1 and the previous sample was 0.
- R6: With the polarity field at 10 or 11, the flag is set whenever two consecutive samples differ.
- R7: A pin pulse that begins and ends between two strobes is never seen.
- R8: In edge operation a set flag stays set until it is acknowledged or cleared by software.
- R9: An acknowledge on a channel clears that channel's flag on the next clock edge.
- R10: On a clock where a channel's software write enable is 1, and neither an acknowledge nor a hardware update is active on that channel, the flag takes the written bit. Channels whose enable is 0 keep their flags.
- R11: A hardware update on a strobe clock (an edge set, or the level load) beats a software write made in the same clock.
- R12: An acknowledge beats both a software set and a hardware update in the same clock. In level operation, a pin that is still low raises the flag again on the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mc_strobe_i | input | 1 | One-clock pulse marking a machine-cycle sample point |
| pin_i | input | NCH | Raw external interrupt pins |
| edge_mode_i | input | NCH | Sense bit per channel: 0 level, 1 edge |
| edge_sel_i | input | 2*NCH | Polarity field per channel; channel i uses bits [2i+1:2i] |
| vec_ack_i | input | NCH | Vector acknowledge per channel, clears the flag |
| sw_we_i | input | NCH | Software write enable per flag |
| sw_data_i | input | NCH | Software write data per flag |
| irq_flag_o | output | NCH | Request flags to the interrupt controller |

## Verification
A flag can receive a hardware update, an acknowledge and a software write on the same clock, so precedence is the central risk. Directed cases line up a strobe that sees a falling edge with a software clear, and an acknowledge with a software set. A later random phase draws strobes, acknowledges, writes, pin values and mode settings independently, so all such collisions occur many times. A behavioural model in the bench applies the precedence order after every clock edge, and the bench compares both flags against that model on each clock.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    // Polarity field codes (bit 1 set means both edges)
    localparam logic [1:0] POL_FALL = 2'b00;
    localparam logic [1:0] POL_RISE = 2'b01;

    typedef struct packed {
        logic smp;   // last machine-cycle sample
        logic flag;  // request flag
    } chan_reg_t;

    function automatic logic pol_match(input logic [1:0] pol,
                                       input logic       prev,
                                       input logic       curr);
        logic rise;
        logic fall;
        rise = ~prev & curr;
        fall = prev & ~curr;
        if (pol[1])
            return rise | fall;
        else if (pol == POL_RISE)
            return rise;
        else
            return fall;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = d_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chain_q <= {STAGES{RST_VAL}};
        else
            chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/irq_chan.sv
module irq_chan
    import ext_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe_i,
    input  logic       pin_s_i,
    input  logic       edge_mode_i,
    input  logic [1:0] pol_i,
    input  logic       ack_i,
    input  logic       sw_we_i,
    input  logic       sw_data_i,
    output logic       flag_o
);

    chan_reg_t r_d, r_q;
    logic      hw_evt;
    logic      hw_val;

    always_comb begin
        r_d    = r_q;
        hw_evt = 1'b0;
        hw_val = 1'b0;
        if (strobe_i) begin
            r_d.smp = pin_s_i;
            if (edge_mode_i) begin
                hw_evt = pol_match(pol_i, r_q.smp, pin_s_i);
                hw_val = 1'b1;
            end else begin
                hw_evt = 1'b1;
                hw_val = ~pin_s_i;
            end
        end
        if (ack_i)
            r_d.flag = 1'b0;
        else if (hw_evt)
            r_d.flag = hw_val;
        else if (sw_we_i)
            r_d.flag = sw_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.smp  <= 1'b1;
            r_q.flag <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign flag_o = r_q.flag;

endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect #(
    parameter int NCH         = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mc_strobe_i,
    input  logic [NCH-1:0]   pin_i,
    input  logic [NCH-1:0]   edge_mode_i,
    input  logic [2*NCH-1:0] edge_sel_i,
    input  logic [NCH-1:0]   vec_ack_i,
    input  logic [NCH-1:0]   sw_we_i,
    input  logic [NCH-1:0]   sw_data_i,
    output logic [NCH-1:0]   irq_flag_o
);

    logic [NCH-1:0] pin_s;

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .d_i   (pin_i[i]),
                .q_o   (pin_s[i])
            );
            irq_chan u_chan (
                .clk         (clk),
                .rst_n       (rst_n),
                .strobe_i    (mc_strobe_i),
                .pin_s_i     (pin_s[i]),
                .edge_mode_i (edge_mode_i[i]),
                .pol_i       (edge_sel_i[2*i +: 2]),
                .ack_i       (vec_ack_i[i]),
                .sw_we_i     (sw_we_i[i]),
                .sw_data_i   (sw_data_i[i]),
                .flag_o      (irq_flag_o[i])
            );
        end
    endgenerate

endmodule

// File: rtl/ext_irq_detect_chk.sv
module ext_irq_detect_chk #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           mc_strobe_i,
    input logic [NCH-1:0] edge_mode_i,
    input logic [NCH-1:0] vec_ack_i,
    input logic [NCH-1:0] sw_we_i,
    input logic [NCH-1:0] sw_data_i,
    input logic [NCH-1:0] irq_flag_o
);

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_a
            a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
                vec_ack_i[i] |=> !irq_flag_o[i]);

            a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
                (!mc_strobe_i && !vec_ack_i[i] && !sw_we_i[i]) |=> $stable(irq_flag_o[i]));

            a_r10_sw_write: assert property (@(posedge clk) disable iff (!rst_n)
                (!mc_strobe_i && !vec_ack_i[i] && sw_we_i[i]) |=> (irq_flag_o[i] == $past(sw_data_i[i])));

            a_r8_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_mode_i[i] && irq_flag_o[i] && !vec_ack_i[i] && !sw_we_i[i]) |=> irq_flag_o[i]);

            a_r12_ack_beats_strobe: assert property (@(posedge clk) disable iff (!rst_n)
                (vec_ack_i[i] && mc_strobe_i) |=> !irq_flag_o[i]);
        end
    endgenerate

endmodule

bind ext_irq_detect ext_irq_detect_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mc_strobe_i (mc_strobe_i),
    .edge_mode_i (edge_mode_i),
    .vec_ack_i   (vec_ack_i),
    .sw_we_i     (sw_we_i),
    .sw_data_i   (sw_data_i),
    .irq_flag_o  (irq_flag_o)
);

// File: tb/ext_irq_detect_test.sv
module ext_irq_detect_test;

    localparam int CLK_PERIOD = 10;
    localparam int MC_DIV     = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_strobe = 1'b0;
    logic [1:0] pin = 2'b11;
    logic [1:0] emode = 2'b00;
    logic [3:0] esel = 4'b0000;
    logic [1:0] ack = 2'b00;
    logic [1:0] swe = 2'b00;
    logic [1:0] swd = 2'b00;
    logic [1:0] flag;

    int    n_tests = 0;
    int    n_fail  = 0;
    string phase   = "R1";
    bit    auto_stb = 1'b1;
    bit    man_stb  = 1'b0;
    int    div_cnt  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_detect #(.NCH(2), .SYNC_STAGES(2)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mc_strobe_i (mc_strobe),
        .pin_i       (pin),
        .edge_mode_i (emode),
        .edge_sel_i  (esel),
        .vec_ack_i   (ack),
        .sw_we_i     (swe),
        .sw_data_i   (swd),
        .irq_flag_o  (flag)
    );

    // strobe source, driven away from the active edge
    always @(negedge clk) begin
        if (auto_stb) begin
            div_cnt   = (div_cnt + 1) % MC_DIV;
            mc_strobe = (div_cnt == 0);
        end else begin
            mc_strobe = man_stb;
        end
    end

    // behavioural reference: pin history queue plus flag precedence
    logic [1:0] pinq[$];
    logic [1:0] m_prev;
    logic [1:0] m_flag;

    always @(posedge clk or negedge rst_n) begin : model
        logic [1:0] seen;
        logic       want;
        logic       cur;
        logic       prv;
        if (!rst_n) begin
            pinq   = '{2'b11, 2'b11};
            m_prev = 2'b11;
            m_flag = 2'b00;
        end else begin
            seen = pinq[0];
            for (int c = 0; c < 2; c++) begin
                cur = seen[c];
                prv = m_prev[c];
                if (esel[2*c+1])      want = (cur != prv);
                else if (esel[2*c])   want = cur && !prv;
                else                  want = !cur && prv;
                if (ack[c])
                    m_flag[c] = 1'b0;
                else if (mc_strobe && emode[c] && want)
                    m_flag[c] = 1'b1;
                else if (mc_strobe && !emode[c])
                    m_flag[c] = !cur;
                else if (swe[c])
                    m_flag[c] = swd[c];
                if (mc_strobe) m_prev[c] = cur;
            end
            pinq.push_back(pin);
            void'(pinq.pop_front());
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            n_tests++;
            if (flag !== m_flag) begin
                n_fail++;
                $display("FAIL %s model compare: actual %b expected %b at %0t",
                         phase, flag, m_flag, $time);
            end
        end
    end

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s directed: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sw_clear();
        swe = 2'b11; swd = 2'b00;
        cyc(1);
        swe = 2'b00;
        cyc(1);
    endtask

    task automatic pulse_strobe();
        man_stb = 1'b1;
        cyc(1);
        man_stb = 1'b0;
        cyc(1);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired (all requirements)");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        phase = "R1";
        check("R1", flag, 2'b00);
        emode = 2'b11; esel = 4'b1010;
        cyc(20);
        check("R1", flag, 2'b00);

        // level sensing
        phase = "R2";
        emode = 2'b00;
        pin = 2'b10;
        cyc(18);
        check("R2", flag, 2'b01);
        pin = 2'b01;
        cyc(18);
        check("R2", flag, 2'b10);
        pin = 2'b11;
        cyc(18);
        check("R2", flag, 2'b00);

        // edge sensing: ch0 falling, ch1 rising
        phase = "R4";
        emode = 2'b11; esel = {2'b01, 2'b00};
        cyc(18);
        sw_clear();
        pin = 2'b00;
        cyc(18);
        check("R4", flag, 2'b01);
        phase = "R8";
        cyc(18);
        check("R8", flag, 2'b01);
        phase = "R5";
        sw_clear();
        pin = 2'b11;
        cyc(18);
        check("R5", flag, 2'b10);

        // both edges, codes 10 and 11
        phase = "R6";
        esel = {2'b11, 2'b10};
        sw_clear();
        pin = 2'b00;
        cyc(18);
        check("R6", flag, 2'b11);
        sw_clear();
        pin = 2'b11;
        cyc(18);
        check("R6", flag, 2'b11);

        // R9: acknowledge clears
        phase = "R9";
        ack = 2'b01;
        cyc(1);
        ack = 2'b00;
        check("R9", flag, 2'b10);

        // manual strobes from here
        auto_stb = 1'b0;
        man_stb  = 1'b0;
        cyc(2);

        // R7: short pulse between strobes, falling and both modes
        phase = "R7";
        esel = {2'b10, 2'b00};
        sw_clear();
        pin = 2'b11;
        cyc(4);
        pulse_strobe();
        sw_clear();
        pin = 2'b00;
        cyc(1);
        pin = 2'b11;
        cyc(5);
        pulse_strobe();
        check("R7", flag, 2'b00);

        // R3: a low pin needs two clocks before a strobe samples it
        phase = "R3";
        esel = {2'b00, 2'b00};
        pin = 2'b10;
        cyc(1);
        pulse_strobe();
        check("R3", flag, 2'b00);
        pin = 2'b11;
        cyc(4);
        pulse_strobe();
        check("R3", flag, 2'b00);

        // R10: per-bit software write
        phase = "R10";
        swe = 2'b10; swd = 2'b11;
        cyc(1);
        swe = 2'b00;
        check("R10", flag, 2'b10);
        swe = 2'b01; swd = 2'b01;
        cyc(1);
        swe = 2'b00;
        check("R10", flag, 2'b11);
        sw_clear();

        // R11: falling edge seen on the same clock as a software clear
        phase = "R11";
        pin = 2'b10;
        cyc(4);
        man_stb = 1'b1; swe = 2'b01; swd = 2'b00;
        cyc(1);
        man_stb = 1'b0; swe = 2'b00;
        check("R11", flag & 2'b01, 2'b01);

        // R12: acknowledge beats software set; level re-raise after ack
        phase = "R12";
        ack = 2'b10; swe = 2'b10; swd = 2'b10;
        cyc(1);
        ack = 2'b00; swe = 2'b00;
        check("R12", flag & 2'b10, 2'b00);
        emode = 2'b00;
        pulse_strobe();
        check("R12", flag, 2'b01);
        ack = 2'b01;
        cyc(1);
        ack = 2'b00;
        check("R12", flag, 2'b00);
        pulse_strobe();
        check("R12", flag, 2'b01);
        pin = 2'b11;
        cyc(4);

        // random mix of all sources, compared every clock
        phase = "R10";
        for (int k = 0; k < 4000; k++) begin
            man_stb = ($urandom_range(0, 2) == 0);
            if ($urandom_range(0, 7) == 0) pin = 2'($urandom);
            if ($urandom_range(0, 99) == 0) begin
                emode = 2'($urandom);
                esel  = 4'($urandom);
            end
            ack = {($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0)};
            swe = {($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0)};
            swd = 2'($urandom);
            cyc(1);
        end
        man_stb = 1'b0; ack = 2'b00; swe = 2'b00;
        cyc(2);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule